// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. A client places one request on a valid/ready handshake: program a byte, fetch the two identifier bytes, return the device to read-array mode, erase the full array, or erase one sector. The sequencer expands each request into the bus write cycles the device's command state machine expects. It times every write and read strobe itself, and on program and erase it polls the device until the internal operation finishes.

The device runs in byte mode, so the two unlock addresses are 0xAAA and 0x555. A sector erase places its confirm byte at the sector address rather than at an unlock address. Completion polling reads one address twice and looks for bit 6 to stop alternating between the two reads. A poll limit turns a device that never settles into an error rather than a hang. A single `done` pulse ends every request, and `err` and the identifier registers are valid on that cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `err` are 0, `nor_ce_n`, `nor_we_n` and `nor_oe_n` are 1, and `nor_dq_oe` is 0.
- R2: Every accepted legal request begins its bus traffic with the writes 0xAA to address 0xAAA and then 0x55 to address 0x555.
- R3: Program (`req_op` = 0) makes four writes: the unlock pair, 0xA0 to 0xAAA, and then `req_data` to `req_addr`. It then polls `req_addr` until the operation completes.
- R4: Identifier read (`req_op` = 1) writes the unlock pair and 0x90 to 0xAAA, waits the settle time, and reads offset 0 into `id_mfr` and offset 2 into `id_dev`. It then writes the unlock pair and 0xF0 to 0xAAA and waits the settle time again, for six writes in total.
- R5: Software reset (`req_op` = 2) makes three writes, the last being 0xF0 to 0xAAA, then waits the settle time.
- R6: Chip erase (`req_op` = 3) makes six writes: the unlock pair, 0x80 to 0xAAA, the unlock pair again, and 0x10 to 0xAAA. It then waits the settle time and polls address 0.
- R7: Sector erase (`req_op` = 4) makes the same six writes as chip erase except the last, which writes 0x30 to `req_addr`. It then polls `req_addr`.
- R8: A chip erase whose `req_addr` is not 0, or whose `req_len` is not 2^AW, ends with `done` and `err` on the cycle after acceptance and makes no bus cycle.
- R9: A poll ends successfully when two back-to-back reads agree in bit 6. If POLL_LIMIT read pairs all disagree, the request ends with `err` = 1.
- R10: During a write, `nor_ce_n` is 0 and `nor_we_n` is low for exactly WE_CYC cycles, with address and data stable throughout. A read holds `nor_oe_n` low for OE_CYC cycles. `nor_we_n` and `nor_oe_n` are never low together.
- R11: `req_ready` falls after a legal request is accepted and returns with `done`. A `req_valid` raised while busy and dropped before `done` causes no bus activity.
- R12: Codes 5 to 7 on `req_op` end with `done` and `err` on the cycle after acceptance and make no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 3 | Operation code (0 to 4, see R3 to R7) |
| req_addr | input | AW | Target byte, sector, or start address |
| req_len | input | AW+1 | Length, checked only for chip erase |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error result of the last request |
| id_mfr | output | 8 | Manufacturer identifier byte |
| id_dev | output | 8 | Device identifier byte |
| nor_addr | output | AW | Flash address bus |
| nor_dq_out | output | 8 | Data driven to flash |
| nor_dq_oe | output | 1 | Enables the data driver |
| nor_dq_in | input | 8 | Data returned by flash |
| nor_ce_n | output | 1 | Chip enable, active low |
| nor_we_n | output | 1 | Write enable, active low |
| nor_oe_n | output | 1 | Output enable, active low |

## Verification
The bench drives a behavioural flash that decodes the unlock and command bytes, returns identifier bytes, and toggles bit 6 for a fixed number of reads after a program or erase. If a design swapped the byte-mode unlock addresses, or sent the sector confirm to 0xAAA, the logged write addresses would show it. A design that skipped the argument check on chip erase would start an erase on a bad length. A design that miscounted the poll would either report done while the flash was still toggling or hang, and this is checked with a flash that never settles. A request raised and withdrawn while the block is busy must leave the write log unchanged.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_ID     = 3'd1,
        OP_RST    = 3'd2,
        OP_CERASE = 3'd3,
        OP_SERASE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        K_WR,
        K_RD_MFR,
        K_RD_DEV,
        K_WAIT,
        K_POLL,
        K_END
    } step_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_BUS,
        SQ_SETTLE
    } seq_st_e;

    typedef enum logic [1:0] {
        B_IDLE,
        B_SETUP,
        B_PULSE,
        B_HOLD
    } bus_st_e;

    localparam logic [7:0] CMD_UNLK1  = 8'hAA;
    localparam logic [7:0] CMD_UNLK2  = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] CMD_EXIT   = 8'hF0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECTOR = 8'h30;

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int AW     = 20,
    parameter int WE_CYC = 2,
    parameter int OE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          cyc_done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] nor_addr,
    output logic [7:0]    nor_dq_out,
    output logic          nor_dq_oe,
    input  logic [7:0]    nor_dq_in,
    output logic          nor_ce_n,
    output logic          nor_we_n,
    output logic          nor_oe_n
);
    localparam int MAXC = (WE_CYC > OE_CYC) ? WE_CYC : OE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        bus_st_e       st;
        logic          rd;
        logic [AW-1:0] a;
        logic [7:0]    dq;
        logic          dq_oe;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic [CW-1:0] cnt;
        logic [7:0]    rdata;
        logic          done;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d      = bus_q;
        bus_d.done = 1'b0;
        case (bus_q.st)
            B_IDLE: if (start) begin
                bus_d.st    = B_SETUP;
                bus_d.rd    = rd;
                bus_d.a     = addr;
                bus_d.dq    = wdata;
                bus_d.dq_oe = !rd;
                bus_d.ce_n  = 1'b0;
            end
            B_SETUP: begin
                bus_d.st = B_PULSE;
                if (bus_q.rd) begin
                    bus_d.oe_n = 1'b0;
                    bus_d.cnt  = CW'(OE_CYC - 1);
                end else begin
                    bus_d.we_n = 1'b0;
                    bus_d.cnt  = CW'(WE_CYC - 1);
                end
            end
            B_PULSE: begin
                if (bus_q.cnt == '0) begin
                    if (bus_q.rd) bus_d.rdata = nor_dq_in;
                    bus_d.we_n = 1'b1;
                    bus_d.oe_n = 1'b1;
                    bus_d.st   = B_HOLD;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            default: begin
                bus_d.ce_n  = 1'b1;
                bus_d.dq_oe = 1'b0;
                bus_d.done  = 1'b1;
                bus_d.st    = B_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q      <= '0;
            bus_q.st   <= B_IDLE;
            bus_q.ce_n <= 1'b1;
            bus_q.we_n <= 1'b1;
            bus_q.oe_n <= 1'b1;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign cyc_done   = bus_q.done;
    assign rdata      = bus_q.rdata;
    assign nor_addr   = bus_q.a;
    assign nor_dq_out = bus_q.dq;
    assign nor_dq_oe  = bus_q.dq_oe;
    assign nor_ce_n   = bus_q.ce_n;
    assign nor_we_n   = bus_q.we_n;
    assign nor_oe_n   = bus_q.oe_n;

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nor_we_n && !nor_oe_n));

    assert_wr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nor_we_n && $past(!nor_we_n)) |-> ($stable(nor_addr) && $stable(nor_dq_out)));

    assert_we_needs_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !nor_we_n |-> (!nor_ce_n && nor_dq_oe));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW         = 20,
    parameter int WE_CYC     = 2,
    parameter int OE_CYC     = 3,
    parameter int SETTLE_CYC = 4,
    parameter int POLL_LIMIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [AW:0]   req_len,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          err,
    output logic [7:0]    id_mfr,
    output logic [7:0]    id_dev,
    output logic [AW-1:0] nor_addr,
    output logic [7:0]    nor_dq_out,
    output logic          nor_dq_oe,
    input  logic [7:0]    nor_dq_in,
    output logic          nor_ce_n,
    output logic          nor_we_n,
    output logic          nor_oe_n
);
    localparam int            SCW      = $clog2(SETTLE_CYC + 1);
    localparam int            PCW      = $clog2(POLL_LIMIT + 1);
    localparam logic [AW:0]   FULL_LEN = {1'b1, {AW{1'b0}}};
    localparam logic [AW-1:0] ADR_A    = AW'(12'hAAA);
    localparam logic [AW-1:0] ADR_B    = AW'(12'h555);

    typedef struct packed {
        seq_st_e        st;
        logic [2:0]     op;
        logic [AW-1:0]  tgt;
        logic [7:0]     wd;
        logic [3:0]     idx;
        logic [SCW-1:0] scnt;
        logic [PCW-1:0] pcnt;
        logic           phase;
        logic [7:0]     first;
        logic [7:0]     mfr;
        logic [7:0]     dev;
        logic           done;
        logic           err;
    } seq_t;

    seq_t          seq_d, seq_q;
    step_kind_e    s_kind;
    logic [AW-1:0] s_addr;
    logic [7:0]    s_data;
    logic          bus_start, bus_done;
    logic [7:0]    bus_rdata;
    logic          req_legal;

    // Legality of an incoming request
    always_comb begin
        req_legal = (req_op <= 3'd4);
        if (req_op == OP_CERASE && (req_addr != '0 || req_len != FULL_LEN))
            req_legal = 1'b0;
    end

    // Step table: what the current index means for the latched operation
    always_comb begin
        s_kind = K_END;
        s_addr = ADR_A;
        s_data = CMD_UNLK1;
        if (seq_q.idx == 4'd0) begin
            s_kind = K_WR;
        end else if (seq_q.idx == 4'd1) begin
            s_kind = K_WR; s_addr = ADR_B; s_data = CMD_UNLK2;
        end else begin
            case (seq_q.op)
                OP_PROG: case (seq_q.idx)
                    4'd2:    begin s_kind = K_WR; s_data = CMD_PROG; end
                    4'd3:    begin s_kind = K_WR; s_addr = seq_q.tgt; s_data = seq_q.wd; end
                    4'd4:    begin s_kind = K_POLL; s_addr = seq_q.tgt; end
                    default: s_kind = K_END;
                endcase
                OP_ID: case (seq_q.idx)
                    4'd2:    begin s_kind = K_WR; s_data = CMD_ID; end
                    4'd3:    s_kind = K_WAIT;
                    4'd4:    begin s_kind = K_RD_MFR; s_addr = '0; end
                    4'd5:    begin s_kind = K_RD_DEV; s_addr = AW'(2); end
                    4'd6:    s_kind = K_WR;
                    4'd7:    begin s_kind = K_WR; s_addr = ADR_B; s_data = CMD_UNLK2; end
                    4'd8:    begin s_kind = K_WR; s_data = CMD_EXIT; end
                    4'd9:    s_kind = K_WAIT;
                    default: s_kind = K_END;
                endcase
                OP_RST: case (seq_q.idx)
                    4'd2:    begin s_kind = K_WR; s_data = CMD_EXIT; end
                    4'd3:    s_kind = K_WAIT;
                    default: s_kind = K_END;
                endcase
                default: case (seq_q.idx)
                    4'd2:    begin s_kind = K_WR; s_data = CMD_ERASE; end
                    4'd3:    s_kind = K_WR;
                    4'd4:    begin s_kind = K_WR; s_addr = ADR_B; s_data = CMD_UNLK2; end
                    4'd5: begin
                        s_kind = K_WR;
                        if (seq_q.op == OP_SERASE) begin
                            s_addr = seq_q.tgt; s_data = CMD_SECTOR;
                        end else begin
                            s_data = CMD_CHIP;
                        end
                    end
                    4'd6:    s_kind = K_WAIT;
                    4'd7: begin
                        s_kind = K_POLL;
                        s_addr = (seq_q.op == OP_SERASE) ? seq_q.tgt : '0;
                    end
                    default: s_kind = K_END;
                endcase
            endcase
        end
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        bus_start  = 1'b0;
        case (seq_q.st)
            SQ_IDLE: if (req_valid) begin
                seq_d.op    = req_op;
                seq_d.tgt   = req_addr;
                seq_d.wd    = req_data;
                seq_d.idx   = '0;
                seq_d.pcnt  = '0;
                seq_d.phase = 1'b0;
                seq_d.err   = 1'b0;
                if (req_legal) begin
                    seq_d.st = SQ_ISSUE;
                end else begin
                    seq_d.done = 1'b1;
                    seq_d.err  = 1'b1;
                end
            end
            SQ_ISSUE: case (s_kind)
                K_WR, K_RD_MFR, K_RD_DEV, K_POLL: begin
                    bus_start = 1'b1;
                    seq_d.st  = SQ_BUS;
                end
                K_WAIT: begin
                    seq_d.scnt = SCW'(SETTLE_CYC - 1);
                    seq_d.st   = SQ_SETTLE;
                end
                default: begin
                    seq_d.done = 1'b1;
                    seq_d.st   = SQ_IDLE;
                end
            endcase
            SQ_BUS: if (bus_done) begin
                seq_d.st = SQ_ISSUE;
                case (s_kind)
                    K_RD_MFR: begin seq_d.mfr = bus_rdata; seq_d.idx = seq_q.idx + 1'b1; end
                    K_RD_DEV: begin seq_d.dev = bus_rdata; seq_d.idx = seq_q.idx + 1'b1; end
                    K_POLL: begin
                        if (!seq_q.phase) begin
                            seq_d.first = bus_rdata;
                            seq_d.phase = 1'b1;
                        end else begin
                            seq_d.phase = 1'b0;
                            if (seq_q.first[6] == bus_rdata[6]) begin
                                seq_d.idx  = seq_q.idx + 1'b1;
                                seq_d.pcnt = '0;
                            end else if (seq_q.pcnt == PCW'(POLL_LIMIT - 1)) begin
                                seq_d.err  = 1'b1;
                                seq_d.done = 1'b1;
                                seq_d.st   = SQ_IDLE;
                            end else begin
                                seq_d.pcnt = seq_q.pcnt + 1'b1;
                            end
                        end
                    end
                    default: seq_d.idx = seq_q.idx + 1'b1;
                endcase
            end
            default: begin
                if (seq_q.scnt == '0) begin
                    seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.st  = SQ_ISSUE;
                end else begin
                    seq_d.scnt = seq_q.scnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= SQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    nor_bus_cycle #(
        .AW     (AW),
        .WE_CYC (WE_CYC),
        .OE_CYC (OE_CYC)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (bus_start),
        .rd         (s_kind != K_WR),
        .addr       (s_addr),
        .wdata      (s_data),
        .cyc_done   (bus_done),
        .rdata      (bus_rdata),
        .nor_addr   (nor_addr),
        .nor_dq_out (nor_dq_out),
        .nor_dq_oe  (nor_dq_oe),
        .nor_dq_in  (nor_dq_in),
        .nor_ce_n   (nor_ce_n),
        .nor_we_n   (nor_we_n),
        .nor_oe_n   (nor_oe_n)
    );

    assign req_ready = (seq_q.st == SQ_IDLE);
    assign done      = seq_q.done;
    assign err       = seq_q.err;
    assign id_mfr    = seq_q.mfr;
    assign id_dev    = seq_q.dev;

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_legal) |=> !req_ready);

    assert_done_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nor_ce_n && nor_we_n && nor_oe_n));

    assert_bad_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == OP_CERASE && req_len != FULL_LEN) |=> (done && err));

    assert_bad_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op > 3'd4) |=> (done && err));

    assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.pcnt < PCW'(POLL_LIMIT));

endmodule

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
    localparam int AW     = 20;
    localparam int WE_CYC = 2;
    localparam int OE_CYC = 3;
    localparam logic [7:0] MFR_ID = 8'h3C;
    localparam logic [7:0] DEV_ID = 8'hA7;
    localparam int NV = 10;
    // op[84:82] addr[81:62] len[61:41] data[40:33] err[32] nwr[31:28] last_addr[27:8] last_data[7:0]
    localparam logic [84:0] VEC [NV] = '{
        {3'd0, 20'h01234, 21'd0,        8'h5A, 1'b0, 4'd4, 20'h01234, 8'h5A},
        {3'd0, 20'hFFFFF, 21'd0,        8'h00, 1'b0, 4'd4, 20'hFFFFF, 8'h00},
        {3'd2, 20'h00000, 21'd0,        8'h00, 1'b0, 4'd3, 20'h00AAA, 8'hF0},
        {3'd3, 20'h00000, 21'h100000,   8'h00, 1'b0, 4'd6, 20'h00AAA, 8'h10},
        {3'd4, 20'h30000, 21'd0,        8'h00, 1'b0, 4'd6, 20'h30000, 8'h30},
        {3'd3, 20'h00010, 21'h100000,   8'h00, 1'b1, 4'd0, 20'h00000, 8'h00},
        {3'd3, 20'h00000, 21'h0FFFFF,   8'h00, 1'b1, 4'd0, 20'h00000, 8'h00},
        {3'd5, 20'h00000, 21'd0,        8'h00, 1'b1, 4'd0, 20'h00000, 8'h00},
        {3'd7, 20'h00000, 21'd0,        8'h00, 1'b1, 4'd0, 20'h00000, 8'h00},
        {3'd1, 20'h00000, 21'd0,        8'h00, 1'b0, 4'd6, 20'h00AAA, 8'hF0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [AW:0]   req_len = '0;
    logic [7:0]    req_data = '0;
    logic          done, err;
    logic [7:0]    id_mfr, id_dev;
    logic [AW-1:0] nor_addr;
    logic [7:0]    nor_dq_out, nor_dq_in;
    logic          nor_dq_oe, nor_ce_n, nor_we_n, nor_oe_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .WE_CYC(WE_CYC), .OE_CYC(OE_CYC), .SETTLE_CYC(4), .POLL_LIMIT(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .done(done), .err(err), .id_mfr(id_mfr), .id_dev(id_dev),
        .nor_addr(nor_addr), .nor_dq_out(nor_dq_out), .nor_dq_oe(nor_dq_oe),
        .nor_dq_in(nor_dq_in), .nor_ce_n(nor_ce_n), .nor_we_n(nor_we_n), .nor_oe_n(nor_oe_n)
    );

    // Behavioural flash model
    logic [AW-1:0] wa [16];
    logic [7:0]    wdv [16];
    int            nwr = 0;
    int            mst = 0;
    logic          idm = 1'b0;
    int            busy = 0;
    logic          tog = 1'b0;
    logic          stuck = 1'b0;
    logic [7:0]    rdv = 8'hFF;
    int            we_low = 0;
    int            oe_low = 0;

    assign nor_dq_in = rdv;

    always @(posedge nor_we_n) begin
        if (rst_n && !nor_ce_n) begin
            if (nwr < 16) begin
                wa[nwr]  = nor_addr;
                wdv[nwr] = nor_dq_out;
            end
            nwr++;
            if (nor_dq_out == 8'hF0 && mst != 3) begin
                mst = 0; idm = 1'b0;
            end else begin
                case (mst)
                    0: mst = (nor_addr == 20'hAAA && nor_dq_out == 8'hAA) ? 1 : 0;
                    1: mst = (nor_addr == 20'h555 && nor_dq_out == 8'h55) ? 2 : 0;
                    2: begin
                        if (nor_dq_out == 8'hA0) mst = 3;
                        else if (nor_dq_out == 8'h90) begin idm = 1'b1; mst = 0; end
                        else if (nor_dq_out == 8'h80) mst = 4;
                        else mst = 0;
                    end
                    3: begin busy = 3; mst = 0; end
                    4: mst = (nor_addr == 20'hAAA && nor_dq_out == 8'hAA) ? 5 : 0;
                    5: mst = (nor_addr == 20'h555 && nor_dq_out == 8'h55) ? 6 : 0;
                    6: begin
                        if (nor_dq_out == 8'h10 || nor_dq_out == 8'h30) busy = 6;
                        mst = 0;
                    end
                    default: mst = 0;
                endcase
            end
        end
    end

    always @(negedge nor_oe_n) begin
        if (rst_n) begin
            if (busy > 0 || stuck) begin
                tog = ~tog;
                if (busy > 0) busy--;
                rdv = {1'b1, tog, 6'h2A};
            end else if (idm) begin
                rdv = (nor_addr == 20'd0) ? MFR_ID : (nor_addr == 20'd2) ? DEV_ID : 8'h00;
            end else begin
                rdv = 8'hFF;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!nor_we_n) we_low++;
            if (!nor_oe_n) oe_low++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic got_err;

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [AW:0] len,
                          input logic [7:0] dat, input logic legal);
        int cyc;
        @(negedge clk);
        nwr = 0; we_low = 0; oe_low = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = len; req_data = dat;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (legal) chk("R11", "ready low after accept", 32'(req_ready), 32'd0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        got_err = err;
        chk("R11", "done seen with ready", 32'(done && req_ready), 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "done/err", {30'd0, done, err}, 32'd0);
        chk("R1", "strobes", {29'd0, nor_ce_n, nor_we_n, nor_oe_n}, 32'd7);
        chk("R1", "dq_oe", 32'(nor_dq_oe), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            int en;
            v = VEC[i];
            en = int'(v[31:28]);
            run_op(v[84:82], v[81:62], v[61:41], v[40:33], !v[32]);
            chk(v[32] ? "R8/R12" : "R3-R7", "err", 32'(got_err), 32'(v[32]));
            chk("R3 R5 R6 R7", "write count", 32'(nwr), 32'(en));
            if (en >= 2) begin
                chk("R2", "unlock1", {4'd0, wa[0], wdv[0]}, {4'd0, 20'hAAA, 8'hAA});
                chk("R2", "unlock2", {4'd0, wa[1], wdv[1]}, {4'd0, 20'h555, 8'h55});
                chk("R3 R5 R6 R7", "last write", {4'd0, wa[en-1], wdv[en-1]},
                    {4'd0, v[27:8], v[7:0]});
            end
            if (v[84:82] == 3'd0)
                chk("R3", "program cmd", {4'd0, wa[2], wdv[2]}, {4'd0, 20'hAAA, 8'hA0});
            if (v[84:82] == 3'd0)
                chk("R10", "we low cycles", 32'(we_low), 32'(4 * WE_CYC));
            if (v[84:82] == 3'd3 || v[84:82] == 3'd4) begin
                chk("R6", "erase setup", {4'd0, wa[2], wdv[2]}, {4'd0, 20'hAAA, 8'h80});
                chk("R6", "second unlock", {4'd0, wa[3], wdv[3]}, {4'd0, 20'hAAA, 8'hAA});
            end
            if (v[84:82] == 3'd1) begin
                chk("R4", "id cmd", {4'd0, wa[2], wdv[2]}, {4'd0, 20'hAAA, 8'h90});
                chk("R4", "mfr", 32'(id_mfr), 32'(MFR_ID));
                chk("R4", "dev", 32'(id_dev), 32'(DEV_ID));
                chk("R10", "oe low cycles", 32'(oe_low), 32'(2 * OE_CYC));
            end
            if (en == 0)
                chk("R8", "no strobe", 32'(we_low + oe_low), 32'd0);
        end

        // R9: flash that never settles ends in error
        stuck = 1'b1;
        run_op(3'd0, 20'h00040, '0, 8'h11, 1'b1);
        chk("R9", "timeout err", 32'(got_err), 32'd1);
        stuck = 1'b0; busy = 0;
        run_op(3'd2, '0, '0, 8'h00, 1'b1);
        chk("R9", "recover after timeout", 32'(got_err), 32'd0);

        // R11: request raised and dropped while busy is ignored
        begin
            int cyc;
            @(negedge clk);
            nwr = 0;
            req_valid = 1'b1; req_op = 3'd0; req_addr = 20'h00777; req_data = 8'h3E;
            @(posedge clk);
            @(negedge clk);
            req_op = 3'd2;
            repeat (5) @(negedge clk);
            req_valid = 1'b0;
            cyc = 0;
            while (!done && cyc < 5000) begin
                @(negedge clk);
                cyc++;
            end
            repeat (10) @(negedge clk);
            chk("R11", "writes after busy request", 32'(nwr), 32'd4);
            chk("R11", "last write target", {4'd0, wa[3], wdv[3]}, {4'd0, 20'h00777, 8'h3E});
            chk("R11", "idle after", 32'(req_ready && nor_ce_n), 32'd1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule